// File: doc/BRIEF.md
# Masked Lookup-Table Unit for Condition Fields

This block holds a small bank of 4-bit condition fields and applies a per-bit Boolean function to them. In each of the four bit positions it takes one bit from each selected source field, forms a lookup index from those bits, and reads the result from a truth table. The result is written into a destination field, but only in the bit positions enabled by a 4-bit write mask. Bit positions that the mask leaves out keep their previous value.

There are two kinds of operation. The three-input kind takes its eight-entry truth table from an 8-bit immediate. The two-input kind takes its four-entry truth table from the whole content of a third condition field, so software can choose the function at run time. A fixed two-input operation such as AND is the two-input kind with a constant table. A registered debug port shows the content of any field.

Top module: `cfield_lut_unit`

## Requirements
- R1: While reset is held, and just after it is released, every field of the bank reads back as zero and `dbg_field` is zero.
- R2: When `op_kind` is 0 (three-input kind), destination bit i takes the value `imm[4*a_i + 2*b_i + c_i]`, where a_i, b_i and c_i are bit i of the fields chosen by `sel_a`, `sel_b` and `sel_c`.
- R3: When `op_kind` is 1 (two-input kind), destination bit i takes the value `T[2*a_i + b_i]`, where T is the 4-bit content of the field chosen by `sel_c`.
- R4: A destination bit i is written only when `wmask[i]` is 1. A bit whose mask bit is 0 keeps its old value.
- R5: A two-input operation whose table field holds 4'h8 produces the bitwise AND of the two source fields.
- R6: All sources are read before the write. When the destination is the same as a source or the table field, the old value of that field is used.
- R7: An operation presented with `issue` high is written into the bank at that rising clock edge. `dbg_field` is a register that loads the field chosen by `dbg_sel` at each rising edge, so a written value shows on `dbg_field` one edge after the write.
- R8: When `issue` is low, no field changes, whatever the other operation inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Perform the operation presented on this cycle |
| op_kind | input | 1 | 0: three-input table from `imm`, 1: two-input table from field `sel_c` |
| sel_a | input | 3 | First source field |
| sel_b | input | 3 | Second source field |
| sel_c | input | 3 | Third source field, or the table field for the two-input kind |
| sel_t | input | 3 | Destination field |
| wmask | input | 4 | Per-bit write enable for the destination |
| imm | input | 8 | Truth table for the three-input kind |
| dbg_sel | input | 3 | Field to show on the debug port |
| dbg_field | output | 4 | Registered content of the field chosen by `dbg_sel` |

## Verification
The assertions check each issued write bit by bit against the lookup rule and the mask. They take for granted that the selectors always name existing fields and that `op_kind`, `imm` and `wmask` are stable around the clock edge. The bench drives every input at the falling edge and uses only selectors from 0 to 7. It loads source fields only through normal masked operations, so the bank never holds a value the assertions have not checked.

// File: rtl/cflut_pkg.sv
package cflut_pkg;

  typedef enum logic {
    OP_TRI = 1'b0,
    OP_DUO = 1'b1
  } op_kind_e;

  // Eight-entry lookup: index formed with a as most significant bit.
  function automatic logic lut_tri(input logic [7:0] tbl, input logic a,
                                   input logic b, input logic c);
    logic [2:0] idx;
    idx = {a, b, c};
    return tbl[idx];
  endfunction

  // Four-entry lookup: index formed with a as most significant bit.
  function automatic logic lut_duo(input logic [3:0] tbl, input logic a,
                                   input logic b);
    logic [1:0] idx;
    idx = {a, b};
    return tbl[idx];
  endfunction

endpackage

// File: rtl/cflut_bank.sv
module cflut_bank #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   rd_a_sel,
  input  logic [SEL_W-1:0]   rd_b_sel,
  input  logic [SEL_W-1:0]   rd_c_sel,
  input  logic [SEL_W-1:0]   rd_t_sel,
  output logic [FIELD_W-1:0] rd_a,
  output logic [FIELD_W-1:0] rd_b,
  output logic [FIELD_W-1:0] rd_c,
  output logic [FIELD_W-1:0] rd_t,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]   dbg_sel,
  output logic [FIELD_W-1:0] dbg_q
);

  logic [FIELD_W-1:0] fields [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(f));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fields[f] <= '0;
      end else if (hit) begin
        fields[f] <= wr_data;
      end
    end
  end

  // Combinational reads: sources see the value before this edge's write.
  assign rd_a = fields[rd_a_sel];
  assign rd_b = fields[rd_b_sel];
  assign rd_c = fields[rd_c_sel];
  assign rd_t = fields[rd_t_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q <= '0;
    end else begin
      dbg_q <= fields[dbg_sel];
    end
  end

endmodule

// File: rtl/cflut_eval.sv
module cflut_eval
  import cflut_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  op_kind_e           op_kind,
  input  logic [7:0]         imm,
  input  logic [FIELD_W-1:0] src_a,
  input  logic [FIELD_W-1:0] src_b,
  input  logic [FIELD_W-1:0] src_c,
  input  logic [FIELD_W-1:0] old_dest,
  input  logic [FIELD_W-1:0] wmask,
  output logic [FIELD_W-1:0] lut_out,
  output logic [FIELD_W-1:0] merged
);

  logic [3:0] duo_tbl;
  assign duo_tbl = src_c[3:0];

  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    logic tri_bit;
    logic duo_bit;
    assign tri_bit    = lut_tri(imm, src_a[i], src_b[i], src_c[i]);
    assign duo_bit    = lut_duo(duo_tbl, src_a[i], src_b[i]);
    assign lut_out[i] = (op_kind == OP_DUO) ? duo_bit : tri_bit;
    assign merged[i]  = wmask[i] ? lut_out[i] : old_dest[i];
  end

endmodule

// File: rtl/cfield_lut_unit.sv
module cfield_lut_unit
  import cflut_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic               op_kind,
  input  logic [SEL_W-1:0]   sel_a,
  input  logic [SEL_W-1:0]   sel_b,
  input  logic [SEL_W-1:0]   sel_c,
  input  logic [SEL_W-1:0]   sel_t,
  input  logic [FIELD_W-1:0] wmask,
  input  logic [7:0]         imm,
  input  logic [SEL_W-1:0]   dbg_sel,
  output logic [FIELD_W-1:0] dbg_field
);

  // Named internal events, observed by the bound checker.
  logic               wr_en;
  logic [FIELD_W-1:0] src_a;
  logic [FIELD_W-1:0] src_b;
  logic [FIELD_W-1:0] src_c;
  logic [FIELD_W-1:0] old_dest;
  logic [FIELD_W-1:0] lut_out;
  logic [FIELD_W-1:0] wr_data;
  op_kind_e           kind;

  assign wr_en = issue;
  assign kind  = op_kind_e'(op_kind);

  cflut_bank #(
    .NUM_FIELDS(NUM_FIELDS),
    .FIELD_W   (FIELD_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_a_sel(sel_a),
    .rd_b_sel(sel_b),
    .rd_c_sel(sel_c),
    .rd_t_sel(sel_t),
    .rd_a    (src_a),
    .rd_b    (src_b),
    .rd_c    (src_c),
    .rd_t    (old_dest),
    .wr_en   (wr_en),
    .wr_sel  (sel_t),
    .wr_data (wr_data),
    .dbg_sel (dbg_sel),
    .dbg_q   (dbg_field)
  );

  cflut_eval #(
    .FIELD_W(FIELD_W)
  ) u_eval (
    .op_kind (kind),
    .imm     (imm),
    .src_a   (src_a),
    .src_b   (src_b),
    .src_c   (src_c),
    .old_dest(old_dest),
    .wmask   (wmask),
    .lut_out (lut_out),
    .merged  (wr_data)
  );

endmodule

// File: rtl/cflut_chk.sv
module cflut_chk #(
  parameter int FIELD_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               op_kind,
  input logic [7:0]         imm,
  input logic [FIELD_W-1:0] wmask,
  input logic [FIELD_W-1:0] src_a,
  input logic [FIELD_W-1:0] src_b,
  input logic [FIELD_W-1:0] src_c,
  input logic [FIELD_W-1:0] old_dest,
  input logic [FIELD_W-1:0] lut_out,
  input logic [FIELD_W-1:0] wr_data,
  input logic [FIELD_W-1:0] dbg_field
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbg_field == '0));

  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    logic [7:0] tri_shift;
    logic [3:0] duo_shift;
    assign tri_shift = imm >> (4 * int'(src_a[i]) + 2 * int'(src_b[i]) + int'(src_c[i]));
    assign duo_shift = src_c[3:0] >> (2 * int'(src_a[i]) + int'(src_b[i]));

    // R2
    tri_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !op_kind && wmask[i]) |-> (wr_data[i] == tri_shift[0]));

    // R3
    duo_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op_kind && wmask[i]) |-> (wr_data[i] == duo_shift[0]));

    // R4
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wmask[i]) |-> (wr_data[i] == old_dest[i]));

    // R4
    mask_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wmask[i]) |-> (wr_data[i] == lut_out[i]));

    // R5
    and_equiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op_kind && wmask[i] && (src_c[3:0] == 4'h8))
        |-> (wr_data[i] == (src_a[i] & src_b[i])));
  end

endmodule

bind cfield_lut_unit cflut_chk #(
  .FIELD_W(FIELD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .op_kind  (op_kind),
  .imm      (imm),
  .wmask    (wmask),
  .src_a    (src_a),
  .src_b    (src_b),
  .src_c    (src_c),
  .old_dest (old_dest),
  .lut_out  (lut_out),
  .wr_data  (wr_data),
  .dbg_field(dbg_field)
);

// File: tb/cfield_lut_unit_tb.sv
module cfield_lut_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic       op_kind = 1'b0;
  logic [2:0] sel_a = '0, sel_b = '0, sel_c = '0, sel_t = '0, dbg_sel = '0;
  logic [3:0] wmask = '0;
  logic [7:0] imm = '0;
  logic [3:0] dbg_field;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [8];

  always #10 clk = ~clk;

  cfield_lut_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_kind(op_kind),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_t(sel_t),
    .wmask(wmask), .imm(imm), .dbg_sel(dbg_sel), .dbg_field(dbg_field)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected result computed arithmetically from the stated lookup rules.
  function automatic logic [3:0] predict(input logic op, input logic [3:0] a,
      input logic [3:0] b, input logic [3:0] c, input logic [3:0] old,
      input logic [3:0] m, input logic [7:0] im);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      int idx;
      int bitv;
      if (op) begin
        idx  = 2 * a[i] + b[i];
        bitv = (int'(c) / (1 << idx)) % 2;
      end else begin
        idx  = 4 * a[i] + 2 * b[i] + c[i];
        bitv = (int'(im) / (1 << idx)) % 2;
      end
      r[i] = m[i] ? bitv[0] : old[i];
    end
    return r;
  endfunction

  task automatic do_op(input logic op, input logic [2:0] a, input logic [2:0] b,
      input logic [2:0] c, input logic [2:0] t, input logic [3:0] m, input logic [7:0] im);
    logic [3:0] nv;
    @(negedge clk);
    nv = predict(op, model[a], model[b], model[c], model[t], m, im);
    issue = 1'b1; op_kind = op; sel_a = a; sel_b = b; sel_c = c; sel_t = t;
    wmask = m; imm = im;
    @(negedge clk);
    issue = 1'b0;
    model[t] = nv;
  endtask

  task automatic read_check(input logic [2:0] f, input string req);
    dbg_sel = f;
    @(negedge clk);
    check(dbg_field, model[f], req);
  endtask

  task automatic load_field(input logic [2:0] f, input logic [3:0] v);
    do_op(1'b0, 3'd0, 3'd0, 3'd0, f, 4'hF, 8'hFF);
    do_op(1'b0, 3'd0, 3'd0, 3'd0, f, ~v, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 8; f++) model[f] = 4'h0;
    repeat (3) @(negedge clk);
    // R1: debug output zero during reset
    check(dbg_field, 4'h0, "R1 during reset");
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++) read_check(3'(f), "R1 field after reset");

    // Source patterns: f1=0011 f2=0101 f3=1111 (f0 stays 0000)
    load_field(3'd1, 4'b0011);
    load_field(3'd2, 4'b0101);
    load_field(3'd3, 4'b1111);
    read_check(3'd1, "R4 load f1");
    read_check(3'd2, "R4 load f2");
    read_check(3'd3, "R4 load f3");

    // R2/R4: sweep every immediate, both index halves, varied masks
    for (int im = 0; im < 256; im++) begin
      for (int p = 0; p < 2; p++) begin
        logic [2:0] dst;
        logic [3:0] m;
        dst = 3'(4 + (im % 4));
        m   = 4'(im) ^ {4{p[0]}};
        do_op(1'b0, p[0] ? 3'd3 : 3'd0, 3'd1, 3'd2, dst, m, 8'(im));
        read_check(dst, "R2 R4 ternary sweep");
      end
    end

    // R3/R4: every table value against every mask
    for (int tb = 0; tb < 16; tb++) begin
      load_field(3'd5, 4'(tb));
      for (int m = 0; m < 16; m++) begin
        do_op(1'b1, 3'd1, 3'd2, 3'd5, 3'd6, 4'(m), 8'h5A);
        read_check(3'd6, "R3 R4 binary sweep");
      end
    end

    // R5: table 4'h8 yields AND of 0011 and 0101
    load_field(3'd5, 4'h8);
    load_field(3'd7, 4'hA);
    do_op(1'b1, 3'd1, 3'd2, 3'd5, 3'd7, 4'hF, 8'h00);
    dbg_sel = 3'd7;
    @(negedge clk);
    check(dbg_field, 4'b0001, "R5 AND via table 8");

    // R8: operation inputs presented without issue change nothing
    load_field(3'd6, 4'h9);
    @(negedge clk);
    op_kind = 1'b0; sel_a = 3'd3; sel_b = 3'd3; sel_c = 3'd3; sel_t = 3'd6;
    wmask = 4'hF; imm = 8'hFF; issue = 1'b0;
    @(negedge clk);
    @(negedge clk);
    read_check(3'd6, "R8 no issue");
    check(dbg_field, 4'h9, "R8 no issue value");

    // R7: debug shows old value one edge after the write, new one the edge after
    load_field(3'd4, 4'h3);
    @(negedge clk);
    dbg_sel = 3'd4;
    issue = 1'b1; op_kind = 1'b0; sel_a = 3'd3; sel_b = 3'd0; sel_c = 3'd0;
    sel_t = 3'd4; wmask = 4'hF; imm = 8'h00;
    @(negedge clk);
    issue = 1'b0;
    check(dbg_field, 4'h3, "R7 old value first edge");
    model[4] = 4'h0;
    @(negedge clk);
    check(dbg_field, 4'h0, "R7 new value second edge");

    // R6: destination equals the table field (OR table 1110)
    load_field(3'd5, 4'hE);
    do_op(1'b1, 3'd1, 3'd2, 3'd5, 3'd5, 4'hF, 8'h00);
    dbg_sel = 3'd5;
    @(negedge clk);
    check(dbg_field, 4'b0111, "R6 table field overwritten");

    // R6: destination equals a source, ternary invert-a (imm 0F)
    do_op(1'b0, 3'd1, 3'd2, 3'd3, 3'd1, 4'hF, 8'h0F);
    dbg_sel = 3'd1;
    @(negedge clk);
    check(dbg_field, 4'b1100, "R6 source overwritten");

    finish_run();
  end

endmodule